// File: doc/BRIEF.md
# Cross-Domain Out-of-Order Issue Queue

This block carries entries from a producer clock domain into a scheduler that runs on an unrelated consumer clock. The producer writes a payload and a ready flag into any free slot. The consumer may take slots out in any order. No write order is kept, so each slot crosses between the domains on its own. An entry only reaches the scheduler after its occupancy has been resynchronized into the consumer clock. That delay is paid on every insertion, and not only when the queue is empty.

Occupancy is kept as a pair of one-bit tokens per slot. The producer flips its token when it fills a slot. The consumer flips its own token when it removes the entry. Each token is carried to the other domain by a falling-edge sample followed by a rising-edge register. In the consumer domain, a slot is visible when the two tokens differ. In the producer domain, a slot is busy when the two tokens differ. The scheduler keeps issuing from the visible entries while later writes are still crossing. A slot that has been removed stays busy in the producer domain until the removal has crossed back.

Top module: `xdom_issue_queue`

## Requirements
- R1: While both resets are low, and after they are released, `p_full` is 0, `c_vis` is all zeros and `c_issue_vld` is 0.
- R2: An accepted write fills the lowest-index slot that the producer sees as free, and at most one slot is allocated per producer cycle.
- R3: `p_full` is 1 exactly when all DEPTH slots are busy in the producer's view. A write presented while `p_full` is 1 is dropped and its payload never issues.
- R4: A slot written at a producer rising edge sets its `c_vis` bit at the first consumer rising edge that follows the first consumer falling edge after that write. Before then it cannot issue.
- R5: When `c_take` is 1 and some slot is both visible and ready, `c_issue_vld` is 1 in the same cycle. `c_issue_idx` then names the lowest such slot and `c_issue_data` carries its payload. The slot is removed at the next consumer rising edge, and its `c_vis` bit is 0 after that edge.
- R6: `c_rdy` bit i is 1 only when slot i is visible and was written with `p_rdy`=1. A visible slot written with `p_rdy`=0 stays visible and never issues.
- R7: A removed slot becomes free to the producer at the first producer rising edge after the first producer falling edge that follows the removal edge. Until then it stays busy, so it counts toward `p_full` and cannot be reused.
- R8: Every accepted payload that was written ready issues exactly once.
- R9: Writes and removals in the two domains proceed independently. An insertion that is still crossing does not stall issue from entries that are already visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| p_clk | input | 1 | Producer clock |
| p_rst_n | input | 1 | Producer synchronous active-low reset |
| p_wr | input | 1 | Write request |
| p_data | input | WIDTH | Payload to insert |
| p_rdy | input | 1 | Ready flag stored with the payload |
| p_full | output | 1 | No slot free in the producer's view |
| c_clk | input | 1 | Consumer clock |
| c_rst_n | input | 1 | Consumer synchronous active-low reset |
| c_take | input | 1 | Scheduler accepts one entry this cycle |
| c_vis | output | DEPTH | Slots visible in the consumer domain |
| c_rdy | output | DEPTH | Visible slots whose ready flag is set |
| c_issue_vld | output | 1 | An entry is issued this cycle |
| c_issue_idx | output | IDXW | Slot of the issued entry |
| c_issue_data | output | WIDTH | Payload of the issued entry |

## Verification
Two things can happen in the same window: a new write lands in one slot while the consumer removes a different slot. A removal can also free a slot while the producer is holding a write against `p_full`. Both cases are provoked by running a stream of writes with retry against an irregular `c_take` pattern on clocks of period 10 ns and 14 ns whose edges never coincide. On every consumer cycle, the visible mask, the ready mask and the chosen slot and payload are compared with a behavioural model of the two domains. On every producer cycle, `p_full` is compared with the same model. A final scoreboard confirms that each ready payload issued exactly once and that the dropped payload never appeared.

// File: rtl/xdq_pkg.sv
`timescale 1ns/100ps
// Shared helpers for the cross-domain issue queue.
// Assumes vectors of at most 32 bits.
package xdq_pkg;

    // Index of the lowest set bit, or 0 when none is set.
    function automatic int lowest_set(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/xdq_sync.sv
`timescale 1ns/100ps
// Per-bit crossing stage: the bits are sampled on the falling edge of the
// destination clock and then registered on its rising edge.
// Assumes each input bit is a single registered signal that changes at most
// once per source cycle (a token), so bits may be carried independently.
module xdq_sync #(
    parameter int N = 4
) (
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] stage_fall;

    // Falling-edge capture of the source tokens.
    always_ff @(negedge dst_clk) begin
        if (!dst_rst_n) stage_fall <= '0;
        else            stage_fall <= async_in;
    end

    // Rising-edge register that feeds destination logic.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) sync_out <= '0;
        else            sync_out <= stage_fall;
    end
endmodule

// File: rtl/xdq_prod.sv
`timescale 1ns/100ps
// Producer side: finds a free slot, stores the payload and ready flag, and
// flips the slot's producer token. A slot is busy while the producer token
// differs from the consumer token carried back into this domain.
// Assumes ctok_p is already synchronized to p_clk.
module xdq_prod #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    parameter int IDXW  = 2
) (
    input  logic                        p_clk,
    input  logic                        p_rst_n,
    input  logic                        p_wr,
    input  logic [WIDTH-1:0]            p_data,
    input  logic                        p_rdy,
    input  logic [DEPTH-1:0]            ctok_p,
    output logic [DEPTH-1:0]            ptok,
    output logic [DEPTH-1:0]            p_busy,
    output logic                        p_full,
    output logic [DEPTH-1:0][WIDTH-1:0] slot_data,
    output logic [DEPTH-1:0]            slot_rdy
);
    logic [IDXW-1:0] free_idx;
    logic            accept;

    // Occupancy view of the producer, and allocation of the lowest free slot.
    always_comb begin
        p_busy   = ptok ^ ctok_p;
        p_full   = &p_busy;
        accept   = p_wr & ~p_full;
        free_idx = IDXW'(xdq_pkg::lowest_set(32'(~p_busy)));
    end

    // Per-slot token flip and storage write on an accepted insertion.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge p_clk) begin
            if (!p_rst_n) begin
                ptok[g]      <= 1'b0;
                slot_data[g] <= '0;
                slot_rdy[g]  <= 1'b0;
            end else if (accept && (free_idx == IDXW'(g))) begin
                ptok[g]      <= ~ptok[g];
                slot_data[g] <= p_data;
                slot_rdy[g]  <= p_rdy;
            end
        end
    end
endmodule

// File: rtl/xdq_cons.sv
`timescale 1ns/100ps
// Consumer side: derives the visible and ready masks, picks the lowest
// visible ready slot when the scheduler takes, and flips the consumer token
// of the issued slot.
// Assumes ptok_c is already synchronized to c_clk. Storage is read only for
// visible slots, whose contents are stable.
module xdq_cons #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    parameter int IDXW  = 2
) (
    input  logic                        c_clk,
    input  logic                        c_rst_n,
    input  logic                        c_take,
    input  logic [DEPTH-1:0]            ptok_c,
    input  logic [DEPTH-1:0][WIDTH-1:0] slot_data,
    input  logic [DEPTH-1:0]            slot_rdy,
    output logic [DEPTH-1:0]            ctok,
    output logic [DEPTH-1:0]            c_vis,
    output logic [DEPTH-1:0]            c_rdy,
    output logic                        c_issue_vld,
    output logic [IDXW-1:0]             c_issue_idx,
    output logic [WIDTH-1:0]            c_issue_data
);
    // Masks and the fixed-priority pick.
    always_comb begin
        c_vis        = ptok_c ^ ctok;
        c_rdy        = c_vis & slot_rdy;
        c_issue_vld  = c_take & (|c_rdy);
        c_issue_idx  = IDXW'(xdq_pkg::lowest_set(32'(c_rdy)));
        c_issue_data = slot_data[c_issue_idx];
    end

    // Removal of the issued slot.
    always_ff @(posedge c_clk) begin
        if (!c_rst_n)         ctok <= '0;
        else if (c_issue_vld) ctok[c_issue_idx] <= ~ctok[c_issue_idx];
    end
endmodule

// File: rtl/xdom_issue_queue.sv
`timescale 1ns/100ps
// Cross-domain issue queue. The producer inserts entries into free slots, and
// the consumer removes visible, ready entries in any order. Each slot's
// occupancy crosses separately in both directions.
// Assumes 2 <= DEPTH <= 32 and that each reset is synchronous to its own clock.
module xdom_issue_queue #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             p_clk,
    input  logic             p_rst_n,
    input  logic             p_wr,
    input  logic [WIDTH-1:0] p_data,
    input  logic             p_rdy,
    output logic             p_full,
    input  logic             c_clk,
    input  logic             c_rst_n,
    input  logic             c_take,
    output logic [DEPTH-1:0] c_vis,
    output logic [DEPTH-1:0] c_rdy,
    output logic             c_issue_vld,
    output logic [IDXW-1:0]  c_issue_idx,
    output logic [WIDTH-1:0] c_issue_data
);
    logic [DEPTH-1:0]            ptok, ctok, ptok_c, ctok_p, p_busy;
    logic [DEPTH-1:0][WIDTH-1:0] slot_data;
    logic [DEPTH-1:0]            slot_rdy;

    xdq_prod #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDXW(IDXW)) u_prod (
        .p_clk(p_clk), .p_rst_n(p_rst_n), .p_wr(p_wr), .p_data(p_data),
        .p_rdy(p_rdy), .ctok_p(ctok_p), .ptok(ptok), .p_busy(p_busy),
        .p_full(p_full), .slot_data(slot_data), .slot_rdy(slot_rdy)
    );

    xdq_sync #(.N(DEPTH)) u_to_cons (
        .dst_clk(c_clk), .dst_rst_n(c_rst_n), .async_in(ptok), .sync_out(ptok_c)
    );

    xdq_sync #(.N(DEPTH)) u_to_prod (
        .dst_clk(p_clk), .dst_rst_n(p_rst_n), .async_in(ctok), .sync_out(ctok_p)
    );

    xdq_cons #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDXW(IDXW)) u_cons (
        .c_clk(c_clk), .c_rst_n(c_rst_n), .c_take(c_take), .ptok_c(ptok_c),
        .slot_data(slot_data), .slot_rdy(slot_rdy), .ctok(ctok),
        .c_vis(c_vis), .c_rdy(c_rdy), .c_issue_vld(c_issue_vld),
        .c_issue_idx(c_issue_idx), .c_issue_data(c_issue_data)
    );
endmodule

// File: rtl/xdom_issue_queue_chk.sv
`timescale 1ns/100ps
// Property checker for the cross-domain issue queue, bound to the top module.
// Assumes resets are held for at least two edges of each clock.
module xdom_issue_queue_chk #(
    parameter int DEPTH = 4,
    parameter int IDXW  = 2
) (
    input logic             p_clk,
    input logic             p_rst_n,
    input logic [DEPTH-1:0] p_busy,
    input logic             c_clk,
    input logic             c_rst_n,
    input logic             c_take,
    input logic [DEPTH-1:0] c_vis,
    input logic [DEPTH-1:0] c_rdy,
    input logic             c_issue_vld,
    input logic [IDXW-1:0]  c_issue_idx
);
    // R5
    issue_visible_chk: assert property (@(posedge c_clk) disable iff (!c_rst_n)
        c_issue_vld |-> c_vis[c_issue_idx]);

    // R6
    issue_ready_chk: assert property (@(posedge c_clk) disable iff (!c_rst_n)
        c_issue_vld |-> c_rdy[c_issue_idx]);

    // R5
    issue_take_chk: assert property (@(posedge c_clk) disable iff (!c_rst_n)
        c_issue_vld |-> c_take);

    // R5
    lowest_pick_chk: assert property (@(posedge c_clk) disable iff (!c_rst_n)
        c_issue_vld |-> ((c_rdy & ~({DEPTH{1'b1}} << c_issue_idx)) == '0));

    // R8
    issue_removes_chk: assert property (@(posedge c_clk) disable iff (!c_rst_n)
        c_issue_vld |=> !c_vis[$past(c_issue_idx)]);

    // R2
    alloc_onehot_chk: assert property (@(posedge p_clk) disable iff (!p_rst_n)
        $onehot0(p_busy & ~$past(p_busy)));
endmodule

bind xdom_issue_queue xdom_issue_queue_chk #(.DEPTH(DEPTH), .IDXW(IDXW)) u_chk (
    .p_clk(p_clk), .p_rst_n(p_rst_n), .p_busy(p_busy),
    .c_clk(c_clk), .c_rst_n(c_rst_n), .c_take(c_take), .c_vis(c_vis),
    .c_rdy(c_rdy), .c_issue_vld(c_issue_vld), .c_issue_idx(c_issue_idx)
);

// File: tb/xdom_issue_queue_tb.sv
`timescale 1ns/100ps
// Bench: behavioural two-domain model compared on every cycle of each clock.
module xdom_issue_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int WIDTH = 8;
    localparam int IDXW  = 2;

    logic p_clk, p_rst_n, p_wr, p_rdy, p_full;
    logic [WIDTH-1:0] p_data;
    logic c_clk, c_rst_n, c_take, c_issue_vld;
    logic [DEPTH-1:0] c_vis, c_rdy;
    logic [IDXW-1:0] c_issue_idx;
    logic [WIDTH-1:0] c_issue_data;

    xdom_issue_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .p_clk(p_clk), .p_rst_n(p_rst_n), .p_wr(p_wr), .p_data(p_data),
        .p_rdy(p_rdy), .p_full(p_full), .c_clk(c_clk), .c_rst_n(c_rst_n),
        .c_take(c_take), .c_vis(c_vis), .c_rdy(c_rdy),
        .c_issue_vld(c_issue_vld), .c_issue_idx(c_issue_idx),
        .c_issue_data(c_issue_data)
    );

    initial p_clk = 0;
    always #(CLK_PERIOD/2) p_clk = ~p_clk;
    initial begin
        c_clk = 0;
        #2.5;
        forever #7 c_clk = ~c_clk;
    end

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model state: occupancy per domain, crossing stages, storage, scoreboard.
    bit [DEPTH-1:0] mp_fill, mc_take, mc_seen1, mc_seen2, mp_seen1, mp_seen2, m_rdy;
    bit [WIDTH-1:0] m_data [DEPTH];
    bit m_acc;
    int issued_cnt [256];
    bit accepted [256], dropped [256], was_rdy [256];
    int issue_log [$];

    function automatic int lowest(input bit [DEPTH-1:0] v);
        for (int i = 0; i < DEPTH; i++) if (v[i]) return i;
        return -1;
    endfunction

    // Producer domain model.
    always @(posedge p_clk) begin
        bit [DEPTH-1:0] busy;
        int k;
        if (!p_rst_n) begin
            mp_fill = '0; mp_seen2 = '0; m_acc = 0;
        end else begin
            busy = mp_fill ^ mp_seen2;
            m_acc = 0;
            if (p_wr) begin
                if (&busy) dropped[p_data] = 1;
                else begin
                    k = lowest(~busy);
                    mp_fill[k] = ~mp_fill[k];
                    m_data[k] = p_data; m_rdy[k] = p_rdy;
                    accepted[p_data] = 1; was_rdy[p_data] = p_rdy; m_acc = 1;
                end
            end
            mp_seen2 = mp_seen1;
            #1;
            if (!done) chk(p_full === &(mp_fill ^ mp_seen2), "R3 R7 p_full",
                           int'(p_full), int'(&(mp_fill ^ mp_seen2)));
        end
    end
    always @(negedge p_clk) mp_seen1 = p_rst_n ? mc_take : '0;

    // Consumer domain model.
    always @(posedge c_clk) begin
        bit [DEPTH-1:0] el;
        int k;
        if (!c_rst_n) begin
            mc_take = '0; mc_seen2 = '0;
        end else begin
            el = (mc_seen2 ^ mc_take) & m_rdy;
            if (c_take && el != 0) begin
                k = lowest(el);
                mc_take[k] = ~mc_take[k];
                issued_cnt[m_data[k]]++;
                issue_log.push_back(int'(m_data[k]));
            end
            mc_seen2 = mc_seen1;
        end
    end
    always @(negedge c_clk) begin
        bit [DEPTH-1:0] ev, er;
        bit evld;
        int k;
        mc_seen1 = c_rst_n ? mp_fill : '0;
        #1;
        if (c_rst_n && p_rst_n && !done) begin
            ev = mc_seen2 ^ mc_take;
            er = ev & m_rdy;
            evld = c_take && (er != 0);
            chk(c_vis === ev, "R4 c_vis", int'(c_vis), int'(ev));
            chk(c_rdy === er, "R6 c_rdy", int'(c_rdy), int'(er));
            chk(c_issue_vld === evld, "R5 R9 c_issue_vld", int'(c_issue_vld), int'(evld));
            if (evld) begin
                k = lowest(er);
                chk(int'(c_issue_idx) == k, "R5 c_issue_idx", int'(c_issue_idx), k);
                chk(c_issue_data === m_data[k], "R5 c_issue_data",
                    int'(c_issue_data), int'(m_data[k]));
            end
        end
    end

    // Producer drivers.
    task automatic push(input int val, input bit rdy);
        p_wr = 1; p_data = WIDTH'(val); p_rdy = rdy;
        do begin @(posedge p_clk); #2; end while (!m_acc);
        p_wr = 0;
    endtask

    task automatic push_one_shot(input int val);
        p_wr = 1; p_data = WIDTH'(val); p_rdy = 1;
        @(posedge p_clk); #2;
        p_wr = 0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; fails++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        bit prod_done;
        bit [7:0] lfsr;
        p_rst_n = 0; c_rst_n = 0; p_wr = 0; p_data = '0; p_rdy = 0; c_take = 0;
        #53;
        p_rst_n = 1; c_rst_n = 1;
        #1;
        // R1: reset state
        chk(p_full === 1'b0, "R1 p_full", int'(p_full), 0);
        chk(c_vis === '0, "R1 c_vis", int'(c_vis), 0);
        chk(c_issue_vld === 1'b0, "R1 c_issue_vld", int'(c_issue_vld), 0);

        // R2 R3: fill every slot, then a write against full is dropped
        push(1, 1); push(2, 1); push(3, 1); push(4, 1);
        chk(p_full === 1'b1, "R3 full after DEPTH writes", int'(p_full), 1);
        push_one_shot(200);
        repeat (4) @(posedge c_clk);
        #2;
        chk(c_vis === 4'hF, "R4 all slots visible", int'(c_vis), 15);
        c_take = 1;
        repeat (8) @(posedge c_clk);
        #2;
        // R2 R5: slots issue in index order, which is the allocation order
        chk(issue_log.size() == 4, "R5 issue count", issue_log.size(), 4);
        for (int i = 0; i < 4 && i < issue_log.size(); i++)
            chk(issue_log[i] == i + 1, "R2 R5 issue order", issue_log[i], i + 1);
        chk(issued_cnt[200] == 0, "R3 dropped payload", issued_cnt[200], 0);

        // R9: concurrent stream against an irregular take pattern
        prod_done = 0;
        lfsr = 8'hA5;
        fork
            begin
                for (int v = 10; v < 50; v++) push(v, 1);
                prod_done = 1;
            end
            begin
                while (!prod_done) begin
                    @(posedge c_clk); #2;
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    c_take = lfsr[0] | lfsr[2];
                end
            end
        join
        c_take = 1;
        repeat (30) @(posedge c_clk);
        #2;

        // R6: an entry written not ready stays visible and never issues
        push(60, 0);
        push(61, 1);
        repeat (20) @(posedge c_clk);
        #2;
        chk(c_vis === 4'h1, "R6 not-ready slot stays visible", int'(c_vis), 1);
        chk(issued_cnt[60] == 0, "R6 not-ready payload issued", issued_cnt[60], 0);
        chk(issued_cnt[61] == 1, "R6 later ready payload", issued_cnt[61], 1);

        // R8: every accepted ready payload issued exactly once
        for (int v = 0; v < 256; v++) begin
            if (accepted[v] && was_rdy[v])
                chk(issued_cnt[v] == 1, "R8 exactly once", issued_cnt[v], 1);
            if (dropped[v] && !accepted[v])
                chk(issued_cnt[v] == 0, "R3 dropped never issues", issued_cnt[v], 0);
        end
        finish_run();
    end
endmodule